// File: doc/BRIEF.md
# PWM generator with sample FIFO

A single-channel pulse width modulator controlled through four memory-mapped registers: control (0x00), status (0x04), sample (0x0C) and period (0x10). Duty values are written into a four-word queue. The generator takes one queued value at a time, holds it for a programmable number of periods, and compares it with a period counter. A prescaler drives that counter, and its input is one of three tick strobes. The result drives one output pin. Software can set that pin to normal polarity, inverted polarity or disconnected.

The counter's period is the programmed value plus two counter steps. While the queue is empty, the last sample in use is applied again. A software reset bit in the control register returns every register to its reset value, empties the queue and then clears itself. Status shows the queue fill level and an empty indication. It also holds three sticky event flags (rollover, compare, write error), which software clears by writing 1 to them.

Register reads are combinational from the address. A write is taken on the rising clock edge where the write strobe is high.

Top module: `pwm_fifo_gen`

## Requirements
- R1: After reset, control reads 0, status reads 0x8, period reads 0xFFFE, sample reads 0, and both the output and the output enable are low.
- R2: One output period lasts (period + 2) counter steps, and a period value of 0xFFFF gives the same length as 0xFFFE. Every counter wrap sets the rollover flag at status bit 4.
- R3: A control field value N in bits [15:4] advances the counter once every N+1 ticks of the selected source.
- R4: The control field in bits [19:18] sets the output mode:
  - 0 is normal and 1 is inverted; in both, the output enable is high while the block is enabled.
  - 2 or 3 is disconnected, which holds both the output enable and the output low.
- R5: In normal mode the output is high from the start of each period while the counter is below the active sample.
  - A sample of 0 gives a constant low output.
  - A sample of (period + 2) or more gives a constant high output.
  - Status bit 5 sets when the counter steps onto the value of the active sample.
- R6: Control bits [17:16] select the counter's tick source: 0 stops the counter, 1 selects `tick_bus`, 2 selects `tick_hf` and 3 selects `tick_slow`.
- R7: The sample queue holds 4 words, used in the order they were written.
  - Status bits [2:0] give the fill level, and status bit 3 is high when the queue is empty.
  - The first sample is loaded one cycle after the enable (control bit 0) is written.
- R8: A sample write while the queue holds 4 words is dropped and sets status bit 6. Writing 1 to status bit 6, 5 or 4 clears that flag.
- R9: Control bits [2:1] = 0, 1, 2 or 3 make each sample last 1, 2, 4 or 8 periods. While the queue is empty, the last sample is reused.
- R10: Writing 1 to control bit 3 makes that bit read 1 for one cycle. After that cycle, every register reads its reset value and the queue is empty.
- R11: The sample register reads the active sample while control bit 0 is set, and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_bus | input | 1 | Tick strobe of source 1 |
| tick_hf | input | 1 | Tick strobe of source 2 |
| tick_slow | input | 1 | Tick strobe of source 3 |
| pwm_out | output | 1 | Modulated output |
| pwm_oe | output | 1 | Output enable, low when disconnected or disabled |

## Verification
The bench builds the block with its default parameters: a 4-word queue, a 16-bit counter and a 12-bit prescaler. These keep the queue-full drop and the order of queued samples within a few writes. They also make the clamp of the largest period value observable: with period 0xFFFF the bench counts 65536 cycles up to the first rollover. High-time counts over whole periods cover the prescaler, the repeat counts and the slower tick sources using small period values.

// File: rtl/pwm_fifo_pkg.sv
`timescale 1ns/1ps
package pwm_fifo_pkg;
    localparam logic [4:0] OFF_CTRL = 5'h00;
    localparam logic [4:0] OFF_STAT = 5'h04;
    localparam logic [4:0] OFF_SAMP = 5'h0C;
    localparam logic [4:0] OFF_PER  = 5'h10;
    localparam int PRE_W = 12;

    typedef enum logic [1:0] {SRC_OFF, SRC_BUS, SRC_HF, SRC_SLOW} clk_src_e;
    typedef enum logic [1:0] {MODE_NORM, MODE_INV, MODE_DISC, MODE_RSVD} out_mode_e;

    // Bit layout is decoded by software: [19:18] mode, [17:16] source,
    // [15:4] divider-1, [3] soft reset, [2:1] repeat, [0] enable
    typedef struct packed {
        out_mode_e        mode;
        clk_src_e         src;
        logic [PRE_W-1:0] div;
        logic             swr;
        logic [1:0]       rep;
        logic             en;
    } ctrl_t;
endpackage

// File: rtl/pwm_sample_fifo.sv
`timescale 1ns/1ps
module pwm_sample_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   fill,
    output logic                         full,
    output logic                         empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int FW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [FW-1:0]           cnt;
    } fifo_t;

    fifo_t q, d;
    logic  do_push, do_pop;

    always_comb begin
        d       = q;
        full    = (q.cnt == FW'(DEPTH));
        empty   = (q.cnt == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            d.mem[q.wp] = din;
            d.wp = (q.wp == PW'(DEPTH-1)) ? '0 : q.wp + 1'b1;
        end
        if (do_pop) begin
            d.rp = (q.rp == PW'(DEPTH-1)) ? '0 : q.rp + 1'b1;
        end
        d.cnt = q.cnt + FW'(do_push) - FW'(do_pop);
        if (clr) d = '0;
    end

    assign dout = q.mem[q.rp];
    assign fill = q.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
    import pwm_fifo_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  clk_src_e         src,
    input  logic [PRE_W-1:0] div,
    input  logic [1:0]       rep_sel,
    input  logic [CNT_W-1:0] period_val,
    input  logic             tick_bus,
    input  logic             tick_hf,
    input  logic             tick_slow,
    input  logic             fifo_empty,
    input  logic [CNT_W-1:0] fifo_dout,
    output logic             pop,
    output logic [CNT_W-1:0] act_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] last_o,
    output logic             raw_high,
    output logic             rollover,
    output logic             cmp_hit
);
    localparam logic [CNT_W-1:0] PER_MAX = {{(CNT_W-1){1'b1}}, 1'b0};

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       rep;
        logic [CNT_W-1:0] act;
        logic             started;
    } tb_t;

    tb_t              q, d;
    logic             src_tick, step;
    logic [CNT_W-1:0] last;
    logic [2:0]       rep_lim;

    always_comb begin
        last = ((period_val >= PER_MAX) ? PER_MAX : period_val) + 1'b1;
        unique case (src)
            SRC_BUS:  src_tick = tick_bus;
            SRC_HF:   src_tick = tick_hf;
            SRC_SLOW: src_tick = tick_slow;
            default:  src_tick = 1'b0;
        endcase
        unique case (rep_sel)
            2'd0:    rep_lim = 3'd0;
            2'd1:    rep_lim = 3'd1;
            2'd2:    rep_lim = 3'd3;
            default: rep_lim = 3'd7;
        endcase
    end

    always_comb begin
        d        = q;
        pop      = 1'b0;
        step     = 1'b0;
        rollover = 1'b0;
        cmp_hit  = 1'b0;
        if (!en || clr) begin
            d = '0;
        end else if (!q.started) begin
            if (!fifo_empty) begin
                pop       = 1'b1;
                d.act     = fifo_dout;
                d.started = 1'b1;
            end
        end else if (src_tick) begin
            if (q.pre == div) begin
                d.pre = '0;
                step  = 1'b1;
            end else begin
                d.pre = q.pre + 1'b1;
            end
        end
        if (step) begin
            if (q.cnt == last) begin
                d.cnt    = '0;
                rollover = 1'b1;
                if (q.rep == rep_lim) begin
                    d.rep = '0;
                    if (!fifo_empty) begin
                        pop   = 1'b1;
                        d.act = fifo_dout;
                    end
                end else begin
                    d.rep = q.rep + 1'b1;
                end
            end else begin
                d.cnt   = q.cnt + 1'b1;
                cmp_hit = ({1'b0, q.cnt} + 1'b1) == {1'b0, q.act};
            end
        end
    end

    assign raw_high = q.started && (q.cnt < q.act);
    assign act_o    = q.act;
    assign cnt_o    = q.cnt;
    assign last_o   = last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/pwm_fifo_gen.sv
`timescale 1ns/1ps
module pwm_fifo_gen
    import pwm_fifo_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        tick_bus,
    input  logic        tick_hf,
    input  logic        tick_slow,
    output logic        pwm_out,
    output logic        pwm_oe
);
    localparam int FW = $clog2(DEPTH+1);
    localparam logic [CNT_W-1:0] PER_RST = {{(CNT_W-1){1'b1}}, 1'b0};

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] period;
        logic             fwe;
        logic             cmp;
        logic             rov;
    } regs_t;

    localparam regs_t REGS_RST = '{ctrl: '0, period: PER_RST, fwe: 1'b0, cmp: 1'b0, rov: 1'b0};

    regs_t            q, d;
    logic             push;
    logic             fifo_full, fifo_empty, tb_pop;
    logic [FW-1:0]    fifo_fill;
    logic [CNT_W-1:0] fifo_dout, act, tb_cnt, tb_last;
    logic             raw_high, tb_rov, tb_cmp;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata[31:20];

    always_comb begin
        d    = q;
        push = 1'b0;
        if (q.ctrl.swr) begin
            d = REGS_RST;
        end else begin
            if (bus_wr) begin
                unique case (bus_addr)
                    OFF_CTRL: begin
                        d.ctrl = ctrl_t'(bus_wdata[19:0]);
                        if (bus_wdata[3]) begin
                            d.ctrl     = '0;
                            d.ctrl.swr = 1'b1;
                        end
                    end
                    OFF_STAT: begin
                        if (bus_wdata[6]) d.fwe = 1'b0;
                        if (bus_wdata[5]) d.cmp = 1'b0;
                        if (bus_wdata[4]) d.rov = 1'b0;
                    end
                    OFF_SAMP: begin
                        if (fifo_full) d.fwe = 1'b1;
                        else           push  = 1'b1;
                    end
                    OFF_PER:  d.period = bus_wdata[CNT_W-1:0];
                    default:  ;
                endcase
            end
            if (tb_rov) d.rov = 1'b1;
            if (tb_cmp) d.cmp = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REGS_RST;
        else        q <= d;
    end

    pwm_sample_fifo #(.DEPTH(DEPTH), .W(CNT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(q.ctrl.swr),
        .push(push), .din(bus_wdata[CNT_W-1:0]), .pop(tb_pop),
        .dout(fifo_dout), .fill(fifo_fill), .full(fifo_full), .empty(fifo_empty)
    );

    pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .clr(q.ctrl.swr), .en(q.ctrl.en),
        .src(q.ctrl.src), .div(q.ctrl.div), .rep_sel(q.ctrl.rep),
        .period_val(q.period), .tick_bus(tick_bus), .tick_hf(tick_hf),
        .tick_slow(tick_slow), .fifo_empty(fifo_empty), .fifo_dout(fifo_dout),
        .pop(tb_pop), .act_o(act), .cnt_o(tb_cnt), .last_o(tb_last),
        .raw_high(raw_high), .rollover(tb_rov), .cmp_hit(tb_cmp)
    );

    always_comb begin
        unique case (bus_addr)
            OFF_CTRL: bus_rdata = {12'b0, q.ctrl};
            OFF_STAT: bus_rdata = {25'b0, q.fwe, q.cmp, q.rov, fifo_empty, 3'(fifo_fill)};
            OFF_SAMP: bus_rdata = q.ctrl.en ? 32'(act) : 32'b0;
            OFF_PER:  bus_rdata = 32'(q.period);
            default:  bus_rdata = 32'b0;
        endcase
    end

    assign pwm_oe  = q.ctrl.en && (q.ctrl.mode == MODE_NORM || q.ctrl.mode == MODE_INV);
    assign pwm_out = pwm_oe && (raw_high ^ (q.ctrl.mode == MODE_INV));
endmodule

// File: rtl/pwm_fifo_gen_chk.sv
`timescale 1ns/1ps
module pwm_fifo_gen_chk #(
    parameter int CNT_W = 16,
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_wr,
    input logic [4:0]                 bus_addr,
    input logic [31:0]                bus_rdata,
    input logic                       pwm_out,
    input logic                       pwm_oe,
    input logic [$clog2(DEPTH+1)-1:0] fill,
    input logic                       swr,
    input logic                       fwe,
    input logic                       en,
    input logic [1:0]                 mode,
    input logic [CNT_W-1:0]           cnt,
    input logic [CNT_W-1:0]           last,
    input logic [CNT_W-1:0]           act
);
    localparam int FW = $clog2(DEPTH+1);

    AST_SWR_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) swr |=> !swr); // R10
    AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) fill <= FW'(DEPTH)); // R7
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 5'h0C && fill == FW'(DEPTH) && !swr) |=> fwe); // R8
    AST_DISCONNECT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1]) |-> (!pwm_oe && !pwm_out)); // R4
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= last); // R2
    AST_ZERO_SAMPLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == 2'd0 && act == '0) |-> !pwm_out); // R5
    AST_SAMPLE_READ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && bus_addr == 5'h0C) |-> bus_rdata == 32'b0); // R11
endmodule

bind pwm_fifo_gen pwm_fifo_gen_chk #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
    .fill(fifo_fill), .swr(q.ctrl.swr), .fwe(q.fwe), .en(q.ctrl.en),
    .mode(q.ctrl.mode), .cnt(tb_cnt), .last(tb_last), .act(act)
);

// File: tb/pwm_fifo_gen_tb.sv
`timescale 1ns/1ps
module pwm_fifo_gen_tb;
    localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_SAMP = 5'h0C, A_PER = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_bus = 1'b1, tick_hf = 1'b0, tick_slow = 1'b0;
    logic        pwm_out, pwm_oe;
    int          total = 0, bad = 0, cyc = 0;

    pwm_fifo_gen u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_bus(tick_bus),
        .tick_hf(tick_hf), .tick_slow(tick_slow), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        cyc++;
        tick_hf   <= (cyc % 2 == 0);
        tick_slow <= (cyc % 3 == 0);
    end

    function automatic logic [31:0] mkc(int en, int rep, int dv, int src, int mode);
        return 32'((mode << 18) | (src << 16) | (dv << 4) | (rep << 1) | en);
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic clean();
        wr(A_CTRL, 32'h8);
        @(negedge clk);
    endtask

    task automatic start(logic [31:0] c);
        wr(A_CTRL, c);
        @(negedge clk);
    endtask

    task automatic win(int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) highs++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
        rd(A_STAT, v); chk("R1 status", v, 32'h8);
        rd(A_PER, v);  chk("R1 period", v, 32'hFFFE);
        rd(A_SAMP, v); chk("R1 sample", v, 32'h0);
        chk("R1 out/oe", {30'b0, pwm_out, pwm_oe}, 32'h0);
    endtask

    task automatic t_basic();
        logic [31:0] v; int h;
        clean();
        wr(A_PER, 3); wr(A_SAMP, 2);
        rd(A_SAMP, v); chk("R11 read disabled", v, 0);
        start(mkc(1, 0, 0, 1, 0));
        chk("R4 oe normal", {31'b0, pwm_oe}, 1);
        win(5, h); chk("R5 highs s=2", h, 2);
        win(5, h); chk("R5 highs s=2 next", h, 2);
        rd(A_SAMP, v); chk("R11 read active", v, 2);
        rd(A_STAT, v); chk("R2 R5 R7 flags", v & 32'h3F, 32'h38);
        wr(A_CTRL, 0);
        wr(A_STAT, 32'h70);
        rd(A_STAT, v); chk("R8 W1C", v, 32'h8);
    endtask

    task automatic t_zero_full();
        logic [31:0] v; int h;
        clean();
        wr(A_PER, 3); wr(A_SAMP, 0); wr(A_SAMP, 7);
        start(mkc(1, 0, 0, 1, 0));
        win(5, h); chk("R5 zero low", h, 0);
        rd(A_STAT, v); chk("R5 no compare at zero", v & 32'h20, 0);
        win(5, h); chk("R5 big high", h, 5);
        win(5, h); chk("R9 reuse last", h, 5);
    endtask

    task automatic t_modes();
        int h;
        clean();
        wr(A_PER, 3); wr(A_SAMP, 2);
        start(mkc(1, 0, 0, 1, 1));
        win(5, h); chk("R4 inverted", h, 3);
        wr(A_CTRL, mkc(1, 0, 0, 1, 2));
        chk("R4 disc oe", {31'b0, pwm_oe}, 0);
        win(5, h); chk("R4 disc out", h, 0);
    endtask

    task automatic t_prescale();
        int h;
        clean();
        wr(A_PER, 3); wr(A_SAMP, 2);
        start(mkc(1, 0, 1, 1, 0));
        win(10, h); chk("R3 div2 highs", h, 4);
        win(10, h); chk("R3 div2 highs next", h, 4);
    endtask

    task automatic t_src();
        logic [31:0] v; int h;
        clean();
        wr(A_PER, 3); wr(A_SAMP, 2);
        start(mkc(1, 0, 0, 0, 0));
        repeat (20) @(negedge clk);
        chk("R6 off holds high", {31'b0, pwm_out}, 1);
        rd(A_STAT, v); chk("R6 off no rollover", v & 32'h10, 0);
        clean();
        wr(A_PER, 3); wr(A_SAMP, 2);
        start(mkc(1, 0, 0, 3, 0));
        repeat (15) @(negedge clk);
        win(15, h); chk("R6 slow source", h, 6);
        clean();
        wr(A_PER, 3); wr(A_SAMP, 2);
        start(mkc(1, 0, 0, 2, 0));
        repeat (10) @(negedge clk);
        win(10, h); chk("R6 hf source", h, 4);
    endtask

    task automatic t_repeat();
        int h;
        clean();
        wr(A_PER, 3); wr(A_SAMP, 1); wr(A_SAMP, 3);
        start(mkc(1, 1, 0, 1, 0));
        win(10, h); chk("R9 2x first", h, 2);
        win(10, h); chk("R9 2x second", h, 6);
        win(5, h);  chk("R9 empty reuse", h, 3);
        clean();
        wr(A_PER, 3); wr(A_SAMP, 2); wr(A_SAMP, 4);
        start(mkc(1, 3, 0, 1, 0));
        win(40, h); chk("R9 8x first", h, 16);
        win(5, h);  chk("R9 8x second", h, 4);
    endtask

    task automatic t_fifo();
        logic [31:0] v; int h;
        clean();
        wr(A_PER, 3);
        for (int i = 1; i <= 5; i++) wr(A_SAMP, i);
        rd(A_STAT, v); chk("R7 R8 full+err", v, 32'h44);
        wr(A_STAT, 32'h40);
        rd(A_STAT, v); chk("R8 clear err", v, 32'h04);
        start(mkc(1, 0, 0, 1, 0));
        for (int i = 1; i <= 4; i++) begin
            win(5, h); chk("R7 order", h, i);
        end
        win(5, h); chk("R8 dropped unused", h, 4);
    endtask

    task automatic t_swr();
        logic [31:0] v;
        clean();
        wr(A_PER, 9); wr(A_SAMP, 1); wr(A_SAMP, 2);
        wr(A_CTRL, 32'h9);
        rd(A_CTRL, v); chk("R10 bit set", v & 32'h8, 32'h8);
        @(negedge clk);
        rd(A_CTRL, v); chk("R10 cleared", v, 0);
        rd(A_STAT, v); chk("R10 flushed", v, 32'h8);
        rd(A_PER, v);  chk("R10 period reset", v, 32'hFFFE);
    endtask

    task automatic roll_time(logic [31:0] per, int exp, string tag);
        logic [31:0] v; int k;
        clean();
        wr(A_PER, per); wr(A_SAMP, 1);
        start(mkc(1, 0, 0, 1, 0));
        k = 0;
        rd(A_STAT, v);
        while (!v[4] && k < 70000) begin
            k++;
            @(negedge clk);
            rd(A_STAT, v);
        end
        chk(tag, k, exp);
    endtask

    initial begin
        #1_900_000;
        bad++;
        $display("FAIL watchdog got=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_zero_full();
        t_modes();
        t_prescale();
        t_src();
        t_repeat();
        t_fifo();
        t_swr();
        roll_time(5, 7, "R2 period 5");
        roll_time(32'hFFFF, 65536, "R2 clamp FFFF");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule